// File: doc/BRIEF.md
# Programmable Two-Input Logic Element Array

The block is a small field-programmable logic fabric built from 32 logic cells, grouped as four clusters of eight. Each cell registers the result of a two-input function. The function comes from a four-entry truth table held in that cell's configuration word. The two operands come from selectable sources.

- **Operand A** is either a software-written data bit or the registered output of an even-numbered cell in the same cluster.
- **Operand B** is either the registered output of an odd-numbered cell in the same cluster or a GPIO pin. Only the lower half of the cells can use a GPIO pin.
- **Chaining.** Cell 0 of each cluster can take the last cell of the previous cluster as its even source, so clusters can be chained.

A single write port loads configuration words, data-input words and a write-once lock. A registered read port returns the cell outputs sixteen at a time. Once the lock is set, the configuration can no longer change until the next reset. Every path, feedback included, passes through a cell register, so the fabric can hold no combinational loop.

Top module: `logic_cell_array`

## Requirements
- R1: A synchronous active-high reset clears every configuration word, every data-input bit, the lock, every cell output and the read data to zero.
- R2: Configuration bits 4:1 are the truth table: the cell output is bit (1 + 2*A + B) of the word, so 1000 gives AND, 0110 XOR, 1110 OR, 0000 constant 0 and 1111 constant 1.
- R3: Configuration bit 6 picks operand A: 0 takes the cell's data-input bit, 1 takes the even feedback source.
- R4: Configuration bits 10:9 pick the even feedback source as cell 0, 2, 4 or 6 of the same cluster for codes 0 to 3; for cells other than cell 0, code 0 means cell 0.
- R5: For cell 0 of a cluster, even code 0 takes the output of cell 7 of the previous cluster; in cluster 0 that input is constant 0.
- R6: Configuration bit 5 picks operand B: 0 takes the odd feedback source chosen by bits 8:7 (cell 1, 3, 5 or 7 of the same cluster for codes 0 to 3), 1 takes GPIO pin i for cell i.
- R7: Cells 16 to 31 ignore bit 5 and always take the odd feedback source as operand B.
- R8: Each cell output is a register that updates on the clock edge after its operands change; a chain of two cells shows its second output one cycle after the first.
- R9: Register map: a write to address 0 to 31 loads configuration word n (bits 10:1 kept). Address 32 loads the data-input bits of cells 0 to 15 (bit i to cell i), and address 33 loads those of cells 16 to 31. Address 34 is the lock. rd_sel 0 returns cells 0 to 15 on rd_data bits 0 to 15 and rd_sel 1 returns cells 16 to 31, one cycle after the select.
- R10: Writing address 34 with bit 0 set sets the lock; writing 0 there does not clear it. While it is set, configuration writes are ignored and data-input writes still take effect. Only reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 6 | Write address (configuration, data-input, lock) |
| wr_data | input | 16 | Write data |
| gpio_in | input | 16 | GPIO operand pins for cells 0 to 15 |
| rd_sel | input | 1 | Output word select |
| rd_data | output | 16 | Registered cell-output word |

## Verification
The bench builds the array with its default parameters: four clusters of eight cells and sixteen-bit words. These values bring the chaining from cluster 0 into cluster 1, and from cluster 2 into cluster 3, within reach. They also cover the tied-low input of cluster 0 and the split between GPIO-capable cells and feedback-only cells at cell 16. Each truth-table code is exercised under all four operand combinations. A two-cell chain is sampled cycle by cycle to pin down the register latency.

// File: rtl/lca_pkg.sv
package lca_pkg;
  // Configuration word field positions (the element decodes these)
  localparam int TBL_LO  = 1;
  localparam int TBL_HI  = 4;
  localparam int B_SRC   = 5;
  localparam int A_SRC   = 6;
  localparam int ODD_LO  = 7;
  localparam int ODD_HI  = 8;
  localparam int EVEN_LO = 9;
  localparam int EVEN_HI = 10;
  localparam int CFG_KEEP = EVEN_HI - TBL_LO + 1;
endpackage

// File: rtl/lca_cfg_regs.sv
module lca_cfg_regs
  import lca_pkg::*;
#(
  parameter int NUM_ELEM  = 32,
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 6,
  localparam int DIN_WORDS = NUM_ELEM / WORD_W,
  localparam int DIN_BASE  = NUM_ELEM,
  localparam int LOCK_ADDR = NUM_ELEM + DIN_WORDS
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [WORD_W-1:0]            wr_data,
  output logic [NUM_ELEM*CFG_KEEP-1:0] cfg_flat,
  output logic [NUM_ELEM-1:0]          din_flat
);

  logic lock_q;

  // Lock: set-only, cleared by reset
  always_ff @(posedge clk) begin
    if (rst)
      lock_q <= 1'b0;
    else if (wr_en && wr_addr == ADDR_W'(LOCK_ADDR) && wr_data[0])
      lock_q <= 1'b1;
  end

  // Configuration words, one per element
  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst)
        cfg_flat[e*CFG_KEEP +: CFG_KEEP] <= '0;
      else if (wr_en && !lock_q && wr_addr == ADDR_W'(e))
        cfg_flat[e*CFG_KEEP +: CFG_KEEP] <= wr_data[EVEN_HI:TBL_LO];
    end
  end

  // Data-input words, never locked
  for (genvar w = 0; w < DIN_WORDS; w++) begin : g_din
    always_ff @(posedge clk) begin
      if (rst)
        din_flat[w*WORD_W +: WORD_W] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(DIN_BASE + w))
        din_flat[w*WORD_W +: WORD_W] <= wr_data;
    end
  end

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(cfg_flat));

endmodule

// File: rtl/lca_element.sv
module lca_element
  import lca_pkg::*;
#(
  parameter int  EPB      = 8,
  parameter int  ELEM_IDX = 0,
  parameter bit  GPIO_OK  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EVEN_HI:TBL_LO] cfg,
  input  logic                 din_bit,
  input  logic                 gpio_bit,
  input  logic                 ext_in,
  input  logic [EPB-1:0]       sib_q,
  output logic                 q
);

  logic [EVEN_HI-EVEN_LO:0] even_sel;
  logic [ODD_HI-ODD_LO:0]   odd_sel;
  logic [TBL_HI-TBL_LO:0]   tbl;
  logic even_fb, odd_fb, op_a, op_b, f;

  assign even_sel = cfg[EVEN_HI:EVEN_LO];
  assign odd_sel  = cfg[ODD_HI:ODD_LO];
  assign tbl      = cfg[TBL_HI:TBL_LO];

  always_comb begin
    if (ELEM_IDX == 0 && even_sel == '0)
      even_fb = ext_in;
    else
      even_fb = sib_q[{even_sel, 1'b0}];
    odd_fb = sib_q[{odd_sel, 1'b1}];
    op_a   = cfg[A_SRC] ? even_fb : din_bit;
    op_b   = (GPIO_OK && cfg[B_SRC]) ? gpio_bit : odd_fb;
    f      = tbl[{op_a, op_b}];
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= f;
  end

  p_tbl_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (tbl == 4'b0000) |=> !q);

  p_tbl_one_r2: assert property (@(posedge clk) disable iff (rst)
    (tbl == 4'b1111) |=> q);

endmodule

// File: rtl/lca_block.sv
module lca_block
  import lca_pkg::*;
#(
  parameter int EPB       = 8,
  parameter int BLOCK_IDX = 0,
  parameter int GPIO_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [EPB*CFG_KEEP-1:0] cfg_blk,
  input  logic [EPB-1:0]          din_blk,
  input  logic [GPIO_W-1:0]       gpio_in,
  input  logic                    ext_in,
  output logic [EPB-1:0]          q_blk
);

  for (genvar e = 0; e < EPB; e++) begin : g_elem
    localparam int GIDX = BLOCK_IDX * EPB + e;
    logic gp;
    if (GIDX < GPIO_W) begin : g_gp
      assign gp = gpio_in[GIDX];
    end else begin : g_nogp
      assign gp = 1'b0;
    end

    lca_element #(
      .EPB      (EPB),
      .ELEM_IDX (e),
      .GPIO_OK  (GIDX < GPIO_W)
    ) u_elem (
      .clk      (clk),
      .rst      (rst),
      .cfg      (cfg_blk[e*CFG_KEEP +: CFG_KEEP]),
      .din_bit  (din_blk[e]),
      .gpio_bit (gp),
      .ext_in   (ext_in),
      .sib_q    (q_blk),
      .q        (q_blk[e])
    );
  end

endmodule

// File: rtl/logic_cell_array.sv
module logic_cell_array
  import lca_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int EPB        = 8,
  parameter int WORD_W     = 16,
  localparam int NUM_ELEM  = NUM_BLOCKS * EPB,
  localparam int GPIO_W    = NUM_ELEM / 2,
  localparam int DIN_WORDS = NUM_ELEM / WORD_W,
  localparam int ADDR_W    = $clog2(NUM_ELEM + DIN_WORDS + 1),
  localparam int RD_SEL_W  = (DIN_WORDS > 1) ? $clog2(DIN_WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [GPIO_W-1:0]   gpio_in,
  input  logic [RD_SEL_W-1:0] rd_sel,
  output logic [WORD_W-1:0]   rd_data
);

  logic [NUM_ELEM*CFG_KEEP-1:0] cfg_flat;
  logic [NUM_ELEM-1:0]          din_flat;
  logic [NUM_ELEM-1:0]          q_all;

  lca_cfg_regs #(
    .NUM_ELEM (NUM_ELEM),
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg_flat (cfg_flat),
    .din_flat (din_flat)
  );

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic ext;
    if (b == 0) begin : g_first
      assign ext = 1'b0;
    end else begin : g_chain
      assign ext = q_all[b*EPB - 1];
    end

    lca_block #(
      .EPB       (EPB),
      .BLOCK_IDX (b),
      .GPIO_W    (GPIO_W)
    ) u_blk (
      .clk     (clk),
      .rst     (rst),
      .cfg_blk (cfg_flat[b*EPB*CFG_KEEP +: EPB*CFG_KEEP]),
      .din_blk (din_flat[b*EPB +: EPB]),
      .gpio_in (gpio_in),
      .ext_in  (ext),
      .q_blk   (q_all[b*EPB +: EPB])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= q_all[int'(rd_sel)*WORD_W +: WORD_W];
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (q_all == '0 && rd_data == '0));

endmodule

// File: tb/tb_logic_cell_array.sv
module tb_logic_cell_array;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] gpio_in = '0;
  logic [0:0]  rd_sel = '0;
  logic [15:0] rd_data;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    int          due;
    string       req;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic_cell_array dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gpio_in(gpio_in), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // Monitor: pops expectations when due
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      n_checks++;
      if (rd_data !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rd_data=%h expected=%h", it.req, rd_data, it.exp);
      end
    end
  end

  function automatic logic [15:0] mk(int ev, int od, bit afb, bit bgp, logic [3:0] tbl);
    return {5'b0, 2'(ev), 2'(od), afb, bgp, tbl, 1'b0};
  endfunction

  task automatic wr(int addr, logic [15:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; gpio_in = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_word(int sel, logic [15:0] exp, string req);
    item_t it;
    @(negedge clk);
    rd_sel = 1'(sel);
    it.exp = exp; it.due = cyc + 2; it.req = req;
    sb.push_back(it);
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    expect_word(0, 16'h0000, "R1");
    expect_word(1, 16'h0000, "R1");

    // R2 R6: every truth table over all operand pairs, A=din, B=gpio
    for (int t = 0; t < 16; t++) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic [3:0] tv;
        bit a, b;
        tv = 4'(t); a = ab[1]; b = ab[0];
        do_reset();
        wr(2, mk(0, 0, 1'b0, 1'b1, tv));
        gpio_in[2] = b;
        wr(32, 16'(a) << 2);
        settle();
        expect_word(0, 16'(tv[{a, b}]) << 2, "R2");
      end
    end

    // R3 R4: even feedback code 1 -> cell 2
    do_reset();
    wr(2, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    wr(3, mk(1, 0, 1'b1, 1'b1, 4'b1100));
    wr(32, 16'h0004);
    settle();
    expect_word(0, 16'h000C, "R3");

    // R4: even code 3 -> cell 6
    do_reset();
    wr(6, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    wr(1, mk(3, 0, 1'b1, 1'b0, 4'b1100));
    wr(32, 16'h0040);
    settle();
    expect_word(0, 16'h0042, "R4");

    // R4 R8: code 0 on cell 2 -> cell 0, latency per stage
    do_reset();
    wr(0, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    wr(2, mk(0, 0, 1'b1, 1'b0, 4'b1100));
    settle();
    wr(32, 16'h0001);
    begin
      item_t it;
      it.req = "R8"; it.exp = 16'h0000; it.due = cyc + 1; sb.push_back(it);
      it.exp = 16'h0001; it.due = cyc + 2; sb.push_back(it);
      it.exp = 16'h0005; it.due = cyc + 3; sb.push_back(it);
    end
    while (sb.size() > 0) @(negedge clk);

    // R6: odd code 2 -> cell 5 ; odd code 3 -> cell 7
    do_reset();
    wr(4, mk(0, 2, 1'b0, 1'b0, 4'b1010));
    wr(5, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    wr(32, 16'h0020);
    settle();
    expect_word(0, 16'h0030, "R6");
    do_reset();
    wr(0, mk(0, 3, 1'b0, 1'b0, 4'b1010));
    wr(7, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    wr(32, 16'h0080);
    settle();
    expect_word(0, 16'h0081, "R6");

    // R5: cluster 0 cell 0 external input is low (NOT A gives 1)
    do_reset();
    wr(0, mk(0, 0, 1'b1, 1'b0, 4'b0011));
    settle();
    expect_word(0, 16'h0001, "R5");

    // R5: cell 7 -> cell 8 across clusters 0 and 1
    do_reset();
    wr(7, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    wr(8, mk(0, 0, 1'b1, 1'b0, 4'b1100));
    wr(32, 16'h0080);
    settle();
    expect_word(0, 16'h0180, "R5");

    // R5 R9: cell 23 -> cell 24, upper word and data word 33
    do_reset();
    wr(23, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    wr(24, mk(0, 0, 1'b1, 1'b0, 4'b1100));
    wr(33, 16'h0080);
    settle();
    expect_word(1, 16'h0180, "R9");
    expect_word(0, 16'h0000, "R9");

    // R7: cell 17 with bit 5 set still takes odd feedback (cell 19)
    do_reset();
    gpio_in = 16'hFFFF;
    wr(17, mk(0, 1, 1'b0, 1'b1, 4'b1010));
    wr(19, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    settle();
    expect_word(1, 16'h0000, "R7");
    wr(33, 16'h0008);
    settle();
    expect_word(1, 16'h000A, "R7");

    // R10: lock freezes configuration, data input still writable
    do_reset();
    wr(0, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    wr(34, 16'h0001);
    wr(0, mk(0, 0, 1'b0, 1'b0, 4'b1111));
    settle();
    expect_word(0, 16'h0000, "R10");
    wr(32, 16'h0001);
    settle();
    expect_word(0, 16'h0001, "R10");
    wr(34, 16'h0000);
    wr(0, mk(0, 0, 1'b0, 1'b0, 4'b0011));
    settle();
    expect_word(0, 16'h0001, "R10");

    // R1 R10: reset clears lock; R1: reset clears data input
    do_reset();
    wr(0, mk(0, 0, 1'b0, 1'b0, 4'b1111));
    settle();
    expect_word(0, 16'h0001, "R1");
    wr(32, 16'hFFFF);
    do_reset();
    wr(0, mk(0, 0, 1'b0, 1'b0, 4'b1100));
    settle();
    expect_word(0, 16'h0000, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule